// File: doc/BRIEF.md
# Paged Address Translator with Lock/Key Protection

This block turns a 16-bit logical word address into an extended physical word address by looking up a page entry. The entry is chosen by three things: the current 4-bit address state, whether the access is operand or instruction, and the top four bits of the logical address. The low twelve logical bits pass straight through, so each page holds 4K words. On every access the block also checks protection against the chosen entry. The checks are a 4-bit lock compared with the 4-bit processor key, a write-protect bit on operand pages and an execute-protect bit on instruction pages. The block raises a protect-ok output when the access is allowed, and reports parity errors in the entry that was used.

Each access is a strobe held high with its inputs held steady. Two cached page entries shorten the lookup. One slot serves instruction accesses and the other serves operand accesses. Under DMA the slots are chosen by transfer direction instead. A cache hit resolves on the first clock edge. A miss refills the slot on that edge and resolves on the next one. The address state and key come from an internal status copy that the CPU loads. While DMA acknowledge is asserted they come from pins instead. Page entries are written and read back through a simple register port.

Top module: `page_mmu`

## Requirements
- R1: After reset, every entry maps as an identity: address state a and page p give physical page {a,p}, the lock is F (all keys pass), both protect bits are 0 and parity is correct. The first access after reset is a cache miss.
- R2: Entry bits [15:12] are the lock, bit [11] is the protect bit, bits [10:8] are the upper page bits, bits [7:0] are the page number and bit [16] is parity. The physical address is {upper, page, laddr[11:0]}. The upper part is forced to 0 unless ext_mode_i is high. paddr_o stays constant while a resolved access is held.
- R3: An access is allowed when the key is 0, when the key equals the lock, or when the lock is F. Any other combination is a violation.
- R4: An operand write to an entry whose bit [11] is set is a violation. Operand reads of that entry are allowed. Any instruction access to an entry whose bit [11] is set is a violation.
- R5: prot_errn_o is low whenever strobe_i is low. It goes high only once the access has resolved with no violation. On a violation it stays low for the whole access.
- R6: hit_o is low while strobe_i is low. On a cache hit, hit_o is high after the first clock edge that samples the strobe high. On a miss it is high one edge later.
- R7: Under CPU control the cache slot is chosen by operand_i (1 = operand). Under DMA it is chosen by rd_wn_i (1 = read). A page that is still held in its slot hits on the next access, even if the other slot was used in between.
- R8: While dma_ack_ni is low, the address state and key come from dma_as_i and dma_ps_i. Otherwise they come from the status copy that sw_we_i loads from sw_as_i and sw_ps_i.
- R9: Parity is odd over the 17 stored bits. par_errn_o goes low when an access resolves on an entry with an even count of ones. Configuration writes store all 17 bits unchecked, and cfg_rdata_o returns them.
- R10: cfg_addr_i = {address state [8:5], space [4] (1 = operand), page [3:0]}. The next access to a rewritten entry uses the new contents, even if the entry was cached.
- R11: Operand and instruction spaces use separate entries for the same address state and page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_mode_i | input | 1 | Use the upper page bits in the physical address |
| sw_we_i | input | 1 | Load the status copy |
| sw_as_i | input | 4 | Address state for the status copy |
| sw_ps_i | input | 4 | Processor key for the status copy |
| dma_ack_ni | input | 1 | DMA acknowledge, active low |
| dma_as_i | input | 4 | Address state from the DMA master |
| dma_ps_i | input | 4 | Processor key from the DMA master |
| strobe_i | input | 1 | Access strobe, held high for the whole access |
| laddr_i | input | 16 | Logical word address |
| operand_i | input | 1 | 1 = operand space, 0 = instruction space |
| rd_wn_i | input | 1 | 1 = read, 0 = write |
| cfg_we_i | input | 1 | Page entry write enable |
| cfg_addr_i | input | 9 | Page entry index |
| cfg_wdata_i | input | 17 | Page entry write data including parity |
| cfg_rdata_o | output | 17 | Page entry read data |
| paddr_o | output | 23 | Physical word address |
| prot_errn_o | output | 1 | Low = protect error or not yet resolved |
| par_errn_o | output | 1 | Low = parity error in the entry used |
| hit_o | output | 1 | High = access resolved (hit or refill done) |

## Verification
The assertions assume three things about the inputs:
- Every access input stays steady while strobe_i is high.
- Entries are written only while the strobe is low, so an access resolves at most two edges after the strobe is first sampled.
- The strobe is low out of reset.

The bench drives each access from a task that changes inputs only on falling clock edges. It makes every configuration write and status load between accesses. It drops the strobe after each access has resolved.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  localparam int PTE_W  = 17;
  localparam int DAT_W  = 16;
  localparam int LOCK_W = 4;
  localparam int RSV_W  = 3;
  localparam int PPA_W  = 8;

  typedef logic [PTE_W-1:0] pte_t;

  // odd parity over data plus parity bit
  function automatic logic pte_par_ok(pte_t e);
    return ^e;
  endfunction

  function automatic pte_t pte_make(logic [LOCK_W-1:0] lock, logic prot,
                                    logic [RSV_W-1:0] rsv, logic [PPA_W-1:0] ppa);
    logic [DAT_W-1:0] d;
    d = {lock, prot, rsv, ppa};
    return {~^d, d};
  endfunction

  function automatic logic key_allows(logic [LOCK_W-1:0] lock, logic [LOCK_W-1:0] key);
    return (key == '0) || (key == lock) || (&lock);
  endfunction
endpackage

// File: rtl/mmu_page_file.sv
module mmu_page_file
  import mmu_pkg::*;
#(
  parameter int SET_W  = 4,
  parameter int PIDX_W = 4,
  parameter int IDX_W  = SET_W + 1 + PIDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  pte_t             wdata_i,
  input  logic [IDX_W-1:0] raddr_a_i,
  input  logic [IDX_W-1:0] raddr_b_i,
  output pte_t             rdata_a_o,
  output pte_t             rdata_b_o
);
  localparam int DEPTH = 1 << IDX_W;

  pte_t mem_q [DEPTH];

  function automatic pte_t ident(int i);
    logic [IDX_W-1:0] ix;
    ix = IDX_W'(i);
    return pte_make('1, 1'b0, '0, PPA_W'({ix[IDX_W-1 -: SET_W], ix[PIDX_W-1:0]}));
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= ident(i);
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/mmu_xlat_cache.sv
module mmu_xlat_cache
  import mmu_pkg::*;
#(
  parameter int TAG_W = 9,
  parameter int WAYS  = 2,
  parameter int SEL_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             fill_i,
  input  pte_t             fill_data_i,
  input  logic             inv_i,
  input  logic [TAG_W-1:0] inv_tag_i,
  output logic             hit_o,
  output pte_t             data_o
);
  logic [WAYS-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q [WAYS];
  pte_t             dat_q [WAYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int w = 0; w < WAYS; w++) begin
        tag_q[w] <= '0;
        dat_q[w] <= '0;
      end
    end else begin
      for (int w = 0; w < WAYS; w++) begin
        if (fill_i && sel_i == SEL_W'(w)) begin
          vld_q[w] <= 1'b1;
          tag_q[w] <= tag_i;
          dat_q[w] <= fill_data_i;
        end
        // a write to the cached entry drops it; checked against the tag after any fill
        if (inv_i && (fill_i && sel_i == SEL_W'(w) ? tag_i : tag_q[w]) == inv_tag_i)
          vld_q[w] <= 1'b0;
      end
    end
  end

  assign hit_o  = vld_q[sel_i] && (tag_q[sel_i] == tag_i);
  assign data_o = dat_q[sel_i];
endmodule

// File: rtl/mmu_access_check.sv
module mmu_access_check
  import mmu_pkg::*;
(
  input  pte_t                     pte_i,
  input  logic [LOCK_W-1:0]        key_i,
  input  logic                     operand_i,
  input  logic                     write_i,
  input  logic                     ext_i,
  output logic                     viol_o,
  output logic                     par_bad_o,
  output logic [RSV_W+PPA_W-1:0]   ppa_o
);
  logic [LOCK_W-1:0] lock;
  logic              prot;

  assign lock      = pte_i[DAT_W-1 -: LOCK_W];
  assign prot      = pte_i[RSV_W+PPA_W];
  assign viol_o    = !key_allows(lock, key_i) || (prot && (operand_i ? write_i : 1'b1));
  assign par_bad_o = !pte_par_ok(pte_i);
  assign ppa_o     = {ext_i ? pte_i[RSV_W+PPA_W-1 -: RSV_W] : {RSV_W{1'b0}}, pte_i[PPA_W-1:0]};
endmodule

// File: rtl/page_mmu.sv
module page_mmu
  import mmu_pkg::*;
#(
  parameter int SET_W = 4,
  parameter int LA_W  = 16,
  parameter int OFS_W = 12
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          ext_mode_i,
  input  logic                          sw_we_i,
  input  logic [SET_W-1:0]              sw_as_i,
  input  logic [LOCK_W-1:0]             sw_ps_i,
  input  logic                          dma_ack_ni,
  input  logic [SET_W-1:0]              dma_as_i,
  input  logic [LOCK_W-1:0]             dma_ps_i,
  input  logic                          strobe_i,
  input  logic [LA_W-1:0]               laddr_i,
  input  logic                          operand_i,
  input  logic                          rd_wn_i,
  input  logic                          cfg_we_i,
  input  logic [SET_W+LA_W-OFS_W:0]     cfg_addr_i,
  input  logic [PTE_W-1:0]              cfg_wdata_i,
  output logic [PTE_W-1:0]              cfg_rdata_o,
  output logic [RSV_W+PPA_W+OFS_W-1:0]  paddr_o,
  output logic                          prot_errn_o,
  output logic                          par_errn_o,
  output logic                          hit_o
);
  localparam int PIDX_W = LA_W - OFS_W;
  localparam int IDX_W  = SET_W + 1 + PIDX_W;
  localparam int PA_W   = RSV_W + PPA_W + OFS_W;

  logic [SET_W-1:0]       sw_as_q, eff_as;
  logic [LOCK_W-1:0]      sw_ps_q, eff_ps;
  logic                   dma, sel, fill, c_hit, viol, par_bad;
  logic [IDX_W-1:0]       idx;
  pte_t                   refill_pte, c_pte;
  logic [RSV_W+PPA_W-1:0] ppa;
  logic                   done_q, hit_q, ok_q, perr_q;
  logic [PA_W-1:0]        pa_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_as_q <= '0;
      sw_ps_q <= '0;
    end else if (sw_we_i) begin
      sw_as_q <= sw_as_i;
      sw_ps_q <= sw_ps_i;
    end
  end

  assign dma    = !dma_ack_ni;
  assign eff_as = dma ? dma_as_i : sw_as_q;
  assign eff_ps = dma ? dma_ps_i : sw_ps_q;
  assign idx    = {eff_as, operand_i, laddr_i[LA_W-1 -: PIDX_W]};
  assign sel    = dma ? rd_wn_i : operand_i;
  assign fill   = strobe_i && !done_q && !c_hit;

  mmu_page_file #(.SET_W(SET_W), .PIDX_W(PIDX_W), .IDX_W(IDX_W)) u_file (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .waddr_i   (cfg_addr_i),
    .wdata_i   (cfg_wdata_i),
    .raddr_a_i (cfg_addr_i),
    .raddr_b_i (idx),
    .rdata_a_o (cfg_rdata_o),
    .rdata_b_o (refill_pte)
  );

  mmu_xlat_cache #(.TAG_W(IDX_W), .WAYS(2)) u_cache (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (sel),
    .tag_i       (idx),
    .fill_i      (fill),
    .fill_data_i (refill_pte),
    .inv_i       (cfg_we_i),
    .inv_tag_i   (cfg_addr_i),
    .hit_o       (c_hit),
    .data_o      (c_pte)
  );

  mmu_access_check u_chk (
    .pte_i     (c_pte),
    .key_i     (eff_ps),
    .operand_i (operand_i),
    .write_i   (!rd_wn_i),
    .ext_i     (ext_mode_i),
    .viol_o    (viol),
    .par_bad_o (par_bad),
    .ppa_o     (ppa)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      hit_q  <= 1'b0;
      ok_q   <= 1'b0;
      perr_q <= 1'b0;
      pa_q   <= '0;
    end else if (!strobe_i) begin
      done_q <= 1'b0;
      hit_q  <= 1'b0;
      ok_q   <= 1'b0;
      perr_q <= 1'b0;
    end else if (!done_q && c_hit) begin
      done_q <= 1'b1;
      hit_q  <= 1'b1;
      ok_q   <= !viol;
      perr_q <= par_bad;
      pa_q   <= {ppa, laddr_i[OFS_W-1:0]};
    end
  end

  assign prot_errn_o = strobe_i && ok_q;
  assign hit_o       = strobe_i && hit_q;
  assign par_errn_o  = !(strobe_i && perr_q);
  assign paddr_o     = pa_q;
endmodule

// File: rtl/page_mmu_checker.sv
module page_mmu_checker #(
  parameter int PA_W = 23
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            strobe_i,
  input logic            hit_o,
  input logic            prot_errn_o,
  input logic            par_errn_o,
  input logic [PA_W-1:0] paddr_o
);
  p_ok_needs_resolve_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_errn_o |-> hit_o);

  p_resolve_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && $past(strobe_i) && $past(strobe_i, 2)) |-> hit_o);

  p_hit_in_access_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hit_o) |-> $past(strobe_i));

  p_paddr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && $past(hit_o)) |-> $stable(paddr_o));

  p_parity_in_access_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_errn_o |-> hit_o);
endmodule

bind page_mmu page_mmu_checker #(.PA_W(23)) i_page_mmu_checker (.*);

// File: tb/test_page_mmu.sv
module test_page_mmu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ext_mode_i = 1'b0;
  logic        sw_we_i = 1'b0;
  logic [3:0]  sw_as_i = '0, sw_ps_i = '0;
  logic        dma_ack_ni = 1'b1;
  logic [3:0]  dma_as_i = '0, dma_ps_i = '0;
  logic        strobe_i = 1'b0;
  logic [15:0] laddr_i = '0;
  logic        operand_i = 1'b1, rd_wn_i = 1'b1;
  logic        cfg_we_i = 1'b0;
  logic [8:0]  cfg_addr_i = '0;
  logic [16:0] cfg_wdata_i = '0;
  logic [16:0] cfg_rdata_o;
  logic [22:0] paddr_o;
  logic        prot_errn_o, par_errn_o, hit_o;

  int checks = 0, bad = 0;
  bit finished = 0;
  logic [16:0] mdl [512];
  logic [3:0]  m_as = '0, m_ps = '0;

  always #2 clk_i = ~clk_i;

  page_mmu i_page_mmu (.*);

  function automatic logic [16:0] ent(logic [3:0] lock, logic prot, logic [2:0] rsv,
                                      logic [7:0] ppa, logic good);
    logic [15:0] d;
    d = {lock, prot, rsv, ppa};
    return {good ? ~^d : ^d, d};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [8:0] a, input logic [16:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    mdl[a] = d;
  endtask

  task automatic set_sw(input logic [3:0] a, input logic [3:0] p);
    @(negedge clk_i);
    sw_we_i = 1'b1; sw_as_i = a; sw_ps_i = p;
    @(negedge clk_i);
    sw_we_i = 1'b0;
    m_as = a; m_ps = p;
  endtask

  task automatic access(input logic op, input logic rd, input logic [15:0] la,
                        input int exp_hit, input string req);
    logic [3:0]  eas, eps, lock;
    logic [16:0] e;
    logic        viol;
    logic [22:0] epa;
    eas  = dma_ack_ni ? m_as : dma_as_i;
    eps  = dma_ack_ni ? m_ps : dma_ps_i;
    e    = mdl[{eas, op, la[15:12]}];
    lock = e[15:12];
    viol = !(eps == 0 || eps == lock || lock == 4'hF) || (e[11] && (op ? !rd : 1'b1));
    epa  = {ext_mode_i ? e[10:8] : 3'b000, e[7:0], la[11:0]};
    @(negedge clk_i);
    operand_i = op; rd_wn_i = rd; laddr_i = la; strobe_i = 1'b1;
    @(negedge clk_i);
    if (exp_hit >= 0) chk({req, " R6 first-edge hit"}, 32'(hit_o), 32'(exp_hit));
    @(negedge clk_i);
    chk({req, " R6 resolved"}, 32'(hit_o), 32'd1);
    chk({req, " R2 paddr"}, 32'(paddr_o), 32'(epa));
    chk({req, " R5 prot"}, 32'(prot_errn_o), 32'(!viol));
    chk({req, " R9 parity"}, 32'(par_errn_o), 32'(^e));
    strobe_i = 1'b0;
    #1;
    chk({req, " R5 idle low"}, 32'({prot_errn_o, hit_o}), 32'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!finished) begin
      bad++; checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 512; i++) begin
      logic [8:0] ix;
      ix = 9'(i);
      mdl[i] = ent(4'hF, 1'b0, 3'b0, {ix[8:5], ix[3:0]}, 1'b1);
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk("R1 idle outputs", 32'({prot_errn_o, hit_o, par_errn_o}), 32'b001);
    cfg_addr_i = 9'h1A3;
    #1;
    chk("R1 reset entry", 32'(cfg_rdata_o), 32'(mdl[9'h1A3]));

    // R1 identity, first access misses, any key passes lock F
    set_sw(4'h3, 4'h7);
    access(1'b1, 1'b1, 16'h5ABC, 0, "R1 identity");
    chk("R1 linear map", 32'(paddr_o), 32'h35ABC);
    access(1'b1, 1'b1, 16'h5123, 1, "R6 repeat hit");

    // R3 lock/key, R10 rewrite of cached entry
    cfg_wr({4'h3, 1'b1, 4'h5}, ent(4'h2, 1'b0, 3'b0, 8'h77, 1'b1));
    access(1'b1, 1'b1, 16'h5ABC, 0, "R10 rewrite refetch");
    chk("R10 new ppa", 32'(paddr_o[19:12]), 32'h77);
    chk("R3 key 7 vs lock 2", 32'(prot_errn_o), 32'd0);
    set_sw(4'h3, 4'h2);
    access(1'b1, 1'b1, 16'h5000, 1, "R3 key equals lock");
    set_sw(4'h3, 4'h0);
    access(1'b1, 1'b0, 16'h5001, 1, "R3 master key");

    // R4 write/execute protect
    cfg_wr({4'h3, 1'b1, 4'h6}, ent(4'hF, 1'b1, 3'b0, 8'h10, 1'b1));
    access(1'b1, 1'b1, 16'h6004, -1, "R4 protected read");
    access(1'b1, 1'b0, 16'h6004, 1, "R4 protected write");
    cfg_wr({4'h3, 1'b0, 4'h6}, ent(4'hF, 1'b1, 3'b0, 8'h11, 1'b1));
    access(1'b0, 1'b1, 16'h6008, 0, "R4 execute protect");

    // R11 separate maps: instruction page 5 still identity
    access(1'b0, 1'b1, 16'h5ABC, -1, "R11 instruction map");
    chk("R11 instr identity", 32'(paddr_o), 32'h35ABC);

    // R2 upper bits by mode
    cfg_wr({4'h3, 1'b1, 4'h8}, ent(4'hF, 1'b0, 3'h5, 8'hC4, 1'b1));
    access(1'b1, 1'b1, 16'h8FFF, -1, "R2 narrow mode");
    ext_mode_i = 1'b1;
    access(1'b1, 1'b1, 16'h8FFF, -1, "R2 extended mode");
    chk("R2 ext paddr", 32'(paddr_o), 32'h5C4FFF);
    ext_mode_i = 1'b0;

    // R9 bad parity stored unchecked and flagged on use
    cfg_wr({4'h3, 1'b1, 4'h9}, ent(4'hF, 1'b0, 3'b0, 8'h21, 1'b0));
    cfg_addr_i = {4'h3, 1'b1, 4'h9};
    #1;
    chk("R9 readback", 32'(cfg_rdata_o), 32'(mdl[{4'h3, 1'b1, 4'h9}]));
    access(1'b1, 1'b1, 16'h9000, -1, "R9 parity error");

    // R8 DMA source from pins
    set_sw(4'h2, 4'h0);
    cfg_wr({4'h9, 1'b1, 4'h1}, ent(4'h4, 1'b0, 3'b0, 8'hE1, 1'b1));
    @(negedge clk_i);
    dma_ack_ni = 1'b0; dma_as_i = 4'h9; dma_ps_i = 4'h6;
    access(1'b1, 1'b1, 16'h1234, -1, "R8 dma pins");
    chk("R8 dma key mismatch", 32'(prot_errn_o), 32'd0);
    dma_ps_i = 4'h4;
    access(1'b1, 1'b1, 16'h1234, -1, "R8 dma key ok");

    // R7 DMA slots by direction
    dma_as_i = 4'h1; dma_ps_i = 4'h0;
    access(1'b1, 1'b1, 16'h6000, 0, "R7 dma read miss");
    access(1'b1, 1'b0, 16'h7000, 0, "R7 dma write miss");
    access(1'b1, 1'b1, 16'h6010, 1, "R7 dma read kept");
    access(1'b1, 1'b0, 16'h7010, 1, "R7 dma write kept");
    @(negedge clk_i);
    dma_ack_ni = 1'b1;

    // R7 CPU slots by space
    set_sw(4'h1, 4'h0);
    access(1'b1, 1'b1, 16'h2000, 0, "R7 cpu op miss");
    access(1'b0, 1'b1, 16'h3000, 0, "R7 cpu instr miss");
    access(1'b1, 1'b0, 16'h2002, 1, "R7 cpu op kept");
    access(1'b0, 1'b1, 16'h3002, 1, "R7 cpu instr kept");
    access(1'b1, 1'b1, 16'h4000, 0, "R7 cpu op replace");
    access(1'b1, 1'b1, 16'h2000, 0, "R7 cpu op evicted");

    // random mix
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(0, 3) == 0)
        cfg_wr(9'($urandom), ent(4'($urandom), 1'($urandom), 3'($urandom), 8'($urandom),
                                 $urandom_range(0, 9) != 0));
      if ($urandom_range(0, 4) == 0) set_sw(4'($urandom_range(0, 3)), 4'($urandom));
      @(negedge clk_i);
      dma_ack_ni = 1'($urandom);
      dma_as_i   = 4'($urandom_range(0, 3));
      dma_ps_i   = 4'($urandom);
      ext_mode_i = 1'($urandom);
      access(1'($urandom), 1'($urandom), {2'b00, 14'($urandom)}, -1, "R3 R4 random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule